// File: doc/BRIEF.md
# Peripheral Sleep and Reset Controller

This block gates the clocks and pulses the resets of up to a few hundred on-chip peripherals, arranged as words of 32 peripherals each. Software programs it through a simple word-addressed write port with a combinational read port. Each peripheral drives a clock-request line into the block and holds it high while it still needs its clock. A clock is switched off only when software has asked for that and the peripheral's own request is low.

System sleep starts when the CPU raises its sleep signal while the sleep-all control bit is set. From that point every peripheral counts as sleep-enabled. The controller then waits in a drain phase until all request lines are low and the PLL condition is met. After that it reports light or heavy sleep, depending on the depth bit. A wake input returns it to the run state on the next clock edge.

Peripheral resets are behind a 32-bit key. Writes to the reset words act only after the unlock key has been written to the key register. Each set bit then produces a one-cycle reset pulse. A separate register bit issues a one-cycle system reset pulse.

Top module: `periph_power_ctrl`

Register map, by byte address: control 0x00, system reset 0x04, key 0x08, sleep-enable word w at 0x10+4w, reset word w at 0x30+4w, clock-request word w at 0x50+4w. Any other address reads 0.

## Requirements
- R1: After reset, every clock enable is 1, no reset pulse is active, both sleep indications are 0, the control register reads 0 and the key register reads 0.
- R2: Peripheral bit b of word w has its clock enable at 0 exactly when (sleep-enable bit is 1, or the controller is out of the run state) and its clock-request bit is 0. Sleep-enable words read back as written.
- R3: Only control bits 0 (heavy depth), 3 (sleep-all) and 8 (allow heavy sleep without PLL lock) are stored. Any other written bits read back as 0.
- R4: With sleep-all set, a sampled CPU sleep request moves the controller into a drain phase, and it enters sleep only after sampling every clock-request bit low. With sleep-all clear, the CPU request has no effect.
- R5: In sleep, the heavy indication is high when control bit 0 is 1 and the light indication is high when it is 0. The two are never high together.
- R6: Sleep is entered only while the PLL-lock input is high, except that heavy sleep may be entered without lock when control bit 8 is 1.
- R7: A sampled wake input returns the controller to the run state at the next edge. The sleep indications drop and the clock enables return to the values programmed in the sleep-enable words.
- R8: Writing 0xA6382D4C to the key register unlocks it and writing 0xA6382D4D locks it. Any other value leaves the state unchanged. The key register reads 1 when unlocked and 0 when locked.
- R9: While unlocked, a write to reset word w drives the written bits on that word's reset outputs for exactly the one cycle after the write edge. Reset words always read 0.
- R10: While locked, writes to the reset words produce no reset pulse.
- R11: Writing the system-reset register with bit 8 set produces a one-cycle system reset pulse. With bit 8 clear, no pulse is produced.
- R12: Clock-request word w reads back the current value of the request inputs for that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Byte address, shared by reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| clk_req | input | NUM_WORDS*32 | Per-peripheral clock requests |
| cpu_sleep | input | 1 | CPU sleep request |
| pll_locked | input | 1 | PLL lock status |
| wake | input | 1 | Wake event, returns to run state |
| clk_en | output | NUM_WORDS*32 | Per-peripheral clock enables |
| periph_rst | output | NUM_WORDS*32 | Per-peripheral one-cycle reset pulses |
| sys_rst | output | 1 | One-cycle system reset pulse |
| light_sleep | output | 1 | Light sleep state |
| heavy_sleep | output | 1 | Heavy sleep state |

## Verification
A wrong sequencer state becomes visible within one cycle. The clock enables of non-requesting peripherals drop while the state should still be run, or the light/heavy outputs rise while a request is still high or while the PLL is unlocked. A wrong key state shows up on the next read of the key register, or as a missing or extra pulse on the reset outputs in the cycle right after the write. A corrupted sleep-enable word shows up on the clock enables and on readback as soon as the register edge passes.

// File: rtl/ppc_pkg.sv
// Package: shared constants and types for the peripheral sleep/reset controller.
// Assumes byte addressing with 32-bit words; index constants are word indices.
package ppc_pkg;
    localparam int DATA_W       = 32;
    // word indices of the register map
    localparam int IDX_CTRL     = 0;
    localparam int IDX_SYSRST   = 1;
    localparam int IDX_KEY      = 2;
    localparam int IDX_SLP_BASE = 4;
    localparam int IDX_RST_BASE = 12;
    localparam int IDX_REQ_BASE = 20;
    localparam int MAX_WORDS    = 8;
    // control register fields
    localparam int CTRL_HEAVY_B  = 0;
    localparam int CTRL_ALL_B    = 3;
    localparam int CTRL_NOLOCK_B = 8;
    localparam logic [DATA_W-1:0] CTRL_MASK = 32'h0000_0109;
    localparam int SYSRST_B      = 8;
    // key register values
    localparam logic [DATA_W-1:0] KEY_OPEN  = 32'hA638_2D4C;
    localparam logic [DATA_W-1:0] KEY_CLOSE = 32'hA638_2D4D;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_DRAIN  = 2'd1,
        ST_ASLEEP = 2'd2
    } pwr_state_t;
endpackage

// File: rtl/ppc_regs.sv
// Module: ppc_regs
// Register file: control, key, sleep-enable words, reset-pulse words,
// system reset pulse and the combinational read mux.
// Assumes NUM_WORDS <= MAX_WORDS so word ranges do not overlap.
module ppc_regs
    import ppc_pkg::*;
#(
    parameter int NUM_WORDS = 5,
    parameter int ADDR_W    = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [DATA_W-1:0]             wdata,
    input  logic [NUM_WORDS*DATA_W-1:0]   req_flat,
    output logic [DATA_W-1:0]             rdata,
    output logic                          sleep_all,
    output logic                          heavy_sel,
    output logic                          allow_nolock,
    output logic [NUM_WORDS*DATA_W-1:0]   sleep_en_flat,
    output logic [NUM_WORDS*DATA_W-1:0]   rst_flat,
    output logic                          sys_rst_pulse
);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0]  widx;
    logic [DATA_W-1:0] ctrl_q;
    logic              unlocked_q;

    assign widx         = addr[ADDR_W-1:2];
    assign sleep_all    = ctrl_q[CTRL_ALL_B];
    assign heavy_sel    = ctrl_q[CTRL_HEAVY_B];
    assign allow_nolock = ctrl_q[CTRL_NOLOCK_B];

    // Control, key state and system reset pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q        <= '0;
            unlocked_q    <= 1'b0;
            sys_rst_pulse <= 1'b0;
        end else begin
            sys_rst_pulse <= 1'b0;
            if (wr_en && widx == IDX_W'(IDX_CTRL))
                ctrl_q <= wdata & CTRL_MASK;
            if (wr_en && widx == IDX_W'(IDX_SYSRST))
                sys_rst_pulse <= wdata[SYSRST_B];
            if (wr_en && widx == IDX_W'(IDX_KEY)) begin
                if (wdata == KEY_OPEN)
                    unlocked_q <= 1'b1;
                else if (wdata == KEY_CLOSE)
                    unlocked_q <= 1'b0;
            end
        end
    end

    for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
        // Sleep-enable word g storage.
        always_ff @(posedge clk) begin
            if (!rst_n)
                sleep_en_flat[g*DATA_W +: DATA_W] <= '0;
            else if (wr_en && widx == IDX_W'(IDX_SLP_BASE + g))
                sleep_en_flat[g*DATA_W +: DATA_W] <= wdata;
        end

        // Reset word g: one-cycle pulse of the written bits when unlocked.
        always_ff @(posedge clk) begin
            if (!rst_n)
                rst_flat[g*DATA_W +: DATA_W] <= '0;
            else if (wr_en && unlocked_q && widx == IDX_W'(IDX_RST_BASE + g))
                rst_flat[g*DATA_W +: DATA_W] <= wdata;
            else
                rst_flat[g*DATA_W +: DATA_W] <= '0;
        end
    end

    // Read mux; reset words and system reset always read 0.
    always_comb begin
        rdata = '0;
        if (widx == IDX_W'(IDX_CTRL))
            rdata = ctrl_q;
        if (widx == IDX_W'(IDX_KEY))
            rdata = {{(DATA_W-1){1'b0}}, unlocked_q};
        for (int w = 0; w < NUM_WORDS; w++) begin
            if (widx == IDX_W'(IDX_SLP_BASE + w))
                rdata = sleep_en_flat[w*DATA_W +: DATA_W];
            if (widx == IDX_W'(IDX_REQ_BASE + w))
                rdata = req_flat[w*DATA_W +: DATA_W];
        end
    end

    // R10: a reset pulse only follows a cycle in which the key was open
    assert_rst_needs_key_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (|rst_flat) |-> $past(unlocked_q));
    // R8: the key state only moves after a write to the key register
    assert_key_moves_on_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(unlocked_q) |-> $past(wr_en && widx == IDX_W'(IDX_KEY)));
    // R11: a system reset pulse never lasts two cycles without a second write
    assert_sysrst_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_rst_pulse && !$past(wr_en)) |-> 1'b0 == 1'b1 ? 1'b0 : $past(wr_en));
endmodule

// File: rtl/ppc_sleep_seq.sv
// Module: ppc_sleep_seq
// Sleep sequencer: run -> drain (waiting for requests and PLL) -> asleep,
// wake returns to run. Assumes the depth bit is stable while asleep.
module ppc_sleep_seq
    import ppc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cpu_sleep,
    input  logic wake,
    input  logic sleep_all,
    input  logic heavy_sel,
    input  logic allow_nolock,
    input  logic pll_locked,
    input  logic req_idle,
    output logic force_gate,
    output logic light,
    output logic heavy
);
    pwr_state_t state_q, state_d;
    logic       pll_ok;

    assign pll_ok = pll_locked || (allow_nolock && heavy_sel);

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_RUN:    if (cpu_sleep && sleep_all && !wake) state_d = ST_DRAIN;
            ST_DRAIN:  if (wake) state_d = ST_RUN;
                       else if (req_idle && pll_ok) state_d = ST_ASLEEP;
            ST_ASLEEP: if (wake) state_d = ST_RUN;
            default:   state_d = ST_RUN;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    assign force_gate = (state_q != ST_RUN);
    assign light      = (state_q == ST_ASLEEP) && !heavy_sel;
    assign heavy      = (state_q == ST_ASLEEP) && heavy_sel;

    // R4: sleep is entered only after all requests were sampled low
    assert_entry_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ASLEEP && $past(state_q) != ST_ASLEEP) |-> $past(req_idle));
    // R6: sleep entry needs PLL lock unless heavy without lock is allowed
    assert_entry_pll_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ASLEEP && $past(state_q) != ST_ASLEEP)
            |-> $past(pll_locked || (allow_nolock && heavy_sel)));
    // R7: a sampled wake brings the sequencer back to run at once
    assert_wake_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wake && state_q != ST_RUN) |=> state_q == ST_RUN);
endmodule

// File: rtl/ppc_gate.sv
// Module: ppc_gate
// Per-peripheral clock gating: a clock stops only when it is sleep-enabled
// (or forced during sleep) and its own request is low.
module ppc_gate
    import ppc_pkg::*;
#(
    parameter int NUM_WORDS = 5
) (
    input  logic [NUM_WORDS*DATA_W-1:0] sleep_en_flat,
    input  logic [NUM_WORDS*DATA_W-1:0] req_flat,
    input  logic                        force_gate,
    output logic [NUM_WORDS*DATA_W-1:0] clk_en_flat,
    output logic                        req_idle
);
    for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
        // Gate word g.
        assign clk_en_flat[g*DATA_W +: DATA_W] =
            ~((sleep_en_flat[g*DATA_W +: DATA_W] | {DATA_W{force_gate}})
              & ~req_flat[g*DATA_W +: DATA_W]);
    end

    assign req_idle = ~|req_flat;
endmodule

// File: rtl/periph_power_ctrl.sv
// Module: periph_power_ctrl (top)
// Peripheral sleep and reset controller: register file, sleep sequencer and
// clock gating. Assumes clk_req is synchronous to clk.
module periph_power_ctrl
    import ppc_pkg::*;
#(
    parameter int NUM_WORDS = 5,
    parameter int ADDR_W    = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_wr,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [31:0]                 bus_wdata,
    output logic [31:0]                 bus_rdata,
    input  logic [NUM_WORDS*32-1:0]     clk_req,
    input  logic                        cpu_sleep,
    input  logic                        pll_locked,
    input  logic                        wake,
    output logic [NUM_WORDS*32-1:0]     clk_en,
    output logic [NUM_WORDS*32-1:0]     periph_rst,
    output logic                        sys_rst,
    output logic                        light_sleep,
    output logic                        heavy_sleep
);
    logic                          sleep_all, heavy_sel, allow_nolock;
    logic                          force_gate, req_idle;
    logic [NUM_WORDS*DATA_W-1:0]   sleep_en_flat;

    ppc_regs #(.NUM_WORDS(NUM_WORDS), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata), .req_flat(clk_req), .rdata(bus_rdata),
        .sleep_all(sleep_all), .heavy_sel(heavy_sel), .allow_nolock(allow_nolock),
        .sleep_en_flat(sleep_en_flat), .rst_flat(periph_rst),
        .sys_rst_pulse(sys_rst)
    );

    ppc_sleep_seq u_seq (
        .clk(clk), .rst_n(rst_n), .cpu_sleep(cpu_sleep), .wake(wake),
        .sleep_all(sleep_all), .heavy_sel(heavy_sel), .allow_nolock(allow_nolock),
        .pll_locked(pll_locked), .req_idle(req_idle), .force_gate(force_gate),
        .light(light_sleep), .heavy(heavy_sleep)
    );

    ppc_gate #(.NUM_WORDS(NUM_WORDS)) u_gate (
        .sleep_en_flat(sleep_en_flat), .req_flat(clk_req), .force_gate(force_gate),
        .clk_en_flat(clk_en), .req_idle(req_idle)
    );

    // R5: the two sleep depths are never indicated together
    assert_depth_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(light_sleep && heavy_sleep));
    // R2: a requesting peripheral always keeps its clock
    assert_req_keeps_clock_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_req & ~clk_en) == '0);
    // R4: a sleep indication implies no request was pending on entry or since
    assert_sleep_needs_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(light_sleep) || $rose(heavy_sleep)) |-> $past(clk_req == '0));
endmodule

// File: tb/periph_power_ctrl_test.sv
module periph_power_ctrl_test;
    localparam int NW = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_wr = 1'b0;
    logic [7:0]        bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [NW*32-1:0]  clk_req = '0;
    logic              cpu_sleep = 1'b0, pll_locked = 1'b1, wake = 1'b0;
    logic [NW*32-1:0]  clk_en, periph_rst;
    logic              sys_rst, light_sleep, heavy_sleep;
    int                checks = 0, errors = 0;

    always #2.5 clk = ~clk;

    periph_power_ctrl #(.NUM_WORDS(NW), .ADDR_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .clk_req(clk_req),
        .cpu_sleep(cpu_sleep), .pll_locked(pll_locked), .wake(wake),
        .clk_en(clk_en), .periph_rst(periph_rst), .sys_rst(sys_rst),
        .light_sleep(light_sleep), .heavy_sleep(heavy_sleep)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // write: drive at a falling edge, release at the next; returns inside the pulse cycle
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] d, se, rq;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        // R1 reset state
        for (int w = 0; w < NW; w++) begin
            chk("R1 clk_en", clk_en[w*32 +: 32], 32'hFFFF_FFFF);
            chk("R1 periph_rst", periph_rst[w*32 +: 32], 32'h0);
        end
        chk("R1 sys_rst", {31'b0, sys_rst}, 32'h0);
        chk("R1 sleep", {30'b0, light_sleep, heavy_sleep}, 32'h0);
        rd(8'h00, d); chk("R1 ctrl", d, 32'h0);
        rd(8'h08, d); chk("R1 key", d, 32'h0);

        // R3 control write mask
        wr(8'h00, 32'hFFFF_FFFF); rd(8'h00, d); chk("R3 ctrl all", d, 32'h0000_0109);
        wr(8'h00, 32'h0000_0EF6); rd(8'h00, d); chk("R3 ctrl none", d, 32'h0);
        wr(8'h00, 32'h0000_0008); rd(8'h00, d); chk("R3 ctrl light", d, 32'h8);
        wr(8'h00, 32'h0);

        // R12 request readback
        for (int w = 0; w < NW; w++)
            clk_req[w*32 +: 32] = 32'h1357_9BDF ^ (32'h1111_1111 * w);
        for (int w = 0; w < NW; w++) begin
            rd(8'(8'h50 + 4*w), d);
            chk("R12 req readback", d, 32'h1357_9BDF ^ (32'h1111_1111 * w));
        end

        // R2 gating sweep: several patterns per word
        for (int p = 0; p < 4; p++) begin
            for (int w = 0; w < NW; w++) begin
                se = {8{4'(p * 5 + w)}} ^ 32'h0F0F_3C3C;
                rq = 32'hA5A5_0FF0 >> p ^ (32'h0101_0101 << w);
                clk_req[w*32 +: 32] = rq;
                wr(8'(8'h10 + 4*w), se);
                rd(8'(8'h10 + 4*w), d);
                chk("R2 sleep-enable readback", d, se);
                chk("R2 gating", clk_en[w*32 +: 32], ~(se & ~rq));
            end
        end

        // R8 key protocol
        rd(8'h08, d); chk("R8 locked", d, 32'h0);
        wr(8'h08, 32'hA638_2D4D); rd(8'h08, d); chk("R8 close while locked", d, 32'h0);
        wr(8'h08, 32'h1234_5678); rd(8'h08, d); chk("R8 junk while locked", d, 32'h0);
        wr(8'h08, 32'hA638_2D4E); rd(8'h08, d); chk("R8 near key", d, 32'h0);

        // R10 locked reset write is ignored
        wr(8'h30, 32'hFFFF_FFFF);
        chk("R10 no pulse", periph_rst[31:0], 32'h0);
        rd(8'h30, d); chk("R10 reads 0", d, 32'h0);

        wr(8'h08, 32'hA638_2D4C); rd(8'h08, d); chk("R8 open", d, 32'h1);
        wr(8'h08, 32'h0); rd(8'h08, d); chk("R8 junk while open", d, 32'h1);
        wr(8'h08, 32'hA638_2D4C); rd(8'h08, d); chk("R8 open again", d, 32'h1);

        // R9 unlocked reset pulses on each word
        for (int w = 0; w < NW; w++) begin
            wr(8'(8'h30 + 4*w), 32'h8000_0001 | (32'h1 << (w * 3)));
            for (int v = 0; v < NW; v++)
                chk("R9 pulse word", periph_rst[v*32 +: 32],
                    (v == w) ? (32'h8000_0001 | (32'h1 << (w * 3))) : 32'h0);
            cyc(1);
            chk("R9 pulse gone", periph_rst[w*32 +: 32], 32'h0);
            rd(8'(8'h30 + 4*w), d); chk("R9 reads 0", d, 32'h0);
        end
        wr(8'h08, 32'hA638_2D4D); rd(8'h08, d); chk("R8 close", d, 32'h0);
        wr(8'h34, 32'h0000_00FF);
        chk("R10 no pulse after close", periph_rst[63:32], 32'h0);

        // R11 system reset
        wr(8'h04, 32'h0000_0100);
        chk("R11 pulse", {31'b0, sys_rst}, 32'h1);
        cyc(1); chk("R11 pulse gone", {31'b0, sys_rst}, 32'h0);
        wr(8'h04, 32'hFFFF_FEFF);
        chk("R11 no pulse without bit 8", {31'b0, sys_rst}, 32'h0);

        // prepare sleep tests: sleep-enable word1 half set, others clear
        clk_req = '0;
        for (int w = 0; w < NW; w++) wr(8'(8'h10 + 4*w), (w == 1) ? 32'h0000_FFFF : 32'h0);

        // R4 no entry without sleep-all
        wr(8'h00, 32'h0);
        cpu_sleep = 1'b1; cyc(3);
        chk("R4 no drain without sleep-all", clk_en[31:0], 32'hFFFF_FFFF);
        chk("R4 no sleep without sleep-all", {30'b0, light_sleep, heavy_sleep}, 32'h0);
        cpu_sleep = 1'b0;

        // R4/R5/R7 light sleep waits for requests
        wr(8'h00, 32'h0000_0008);
        clk_req[3] = 1'b1;
        @(negedge clk); cpu_sleep = 1'b1;
        cyc(1);
        chk("R4 drain forces gating", clk_en[31:0], 32'h0000_0008);
        cyc(4);
        chk("R4 waits for request", {30'b0, light_sleep, heavy_sleep}, 32'h0);
        clk_req[3] = 1'b0;
        cyc(1);
        chk("R5 light", {30'b0, light_sleep, heavy_sleep}, 32'h2);
        chk("R4 asleep gating", clk_en[63:32], 32'h0);
        cpu_sleep = 1'b0; wake = 1'b1;
        cyc(1); wake = 1'b0;
        chk("R7 wake leaves sleep", {30'b0, light_sleep, heavy_sleep}, 32'h0);
        chk("R7 clk restore word1", clk_en[63:32], 32'hFFFF_0000);
        chk("R7 clk restore word0", clk_en[31:0], 32'hFFFF_FFFF);

        // R6 heavy sleep without lock, allowed
        pll_locked = 1'b0;
        wr(8'h00, 32'h0000_0109);
        @(negedge clk); cpu_sleep = 1'b1;
        cyc(2);
        chk("R6 heavy allowed without lock", {30'b0, light_sleep, heavy_sleep}, 32'h1);
        cpu_sleep = 1'b0; wake = 1'b1; cyc(1); wake = 1'b0;
        chk("R7 wake from heavy", {30'b0, light_sleep, heavy_sleep}, 32'h0);

        // R6 light sleep without lock waits even with bit 8
        wr(8'h00, 32'h0000_0108);
        @(negedge clk); cpu_sleep = 1'b1;
        cyc(4);
        chk("R6 light needs lock", {30'b0, light_sleep, heavy_sleep}, 32'h0);
        pll_locked = 1'b1;
        cyc(1);
        chk("R6 light after lock", {30'b0, light_sleep, heavy_sleep}, 32'h2);
        cpu_sleep = 1'b0; wake = 1'b1; cyc(1); wake = 1'b0;

        // R6 heavy without bit 8 needs lock
        pll_locked = 1'b0;
        wr(8'h00, 32'h0000_0009);
        @(negedge clk); cpu_sleep = 1'b1;
        cyc(4);
        chk("R6 heavy needs lock", {30'b0, light_sleep, heavy_sleep}, 32'h0);
        pll_locked = 1'b1;
        cyc(1);
        chk("R5 heavy", {30'b0, light_sleep, heavy_sleep}, 32'h1);
        cpu_sleep = 1'b0; wake = 1'b1; cyc(1); wake = 1'b0;
        chk("R7 back to run", clk_en[63:32], 32'hFFFF_0000);

        finish_run();
    end
endmodule